// File: doc/BRIEF.md
# Microprogram Sequencer with Bit-OR Dispatch

This block is the control unit of a microcoded processor. It holds a micro-program counter, a read-only control store of microinstructions and the logic that picks the next micro-address. It presents the control word of the current microinstruction to a single-bus datapath. That word raises register gating, memory read, ALU add and similar strobes, along with a wait-for-memory flag and an end-of-instruction flag.

Most microinstructions fall through to the next address. Four other moves are possible:
- A dispatch step takes a start address from the instruction decoder and ORs the addressing-mode field of the instruction into it, so that one entry point fans out to a separate routine for each mode.
- A jump step loads the microinstruction's own address field. It can OR the low mode bit into micro-address bit 0, which skips the extra memory read for direct modes.
- A conditional step returns to the fetch routine when the negative flag is clear.
- A microinstruction that waits for memory holds the micro-PC until the memory reports completion.

The end flag sends the sequencer back to the fetch routine at address 0.

Top module: `useq`

## Requirements
- R1: While rst_n is low the micro-PC is 0 and the control word is 0x007D. That value is the fetch word: bit 0 PC-out, bit 2 MAR-in, bit 3 read, bit 4 select-constant, bit 5 add and bit 6 Z-in. Bits 1 PC-in, 7 Z-out, 8 Y-in, 9 MDR-out, 10 IR-in, 11 src-out, 12 src-in, 13 dst-out, 14 dst-in and 15 offset-out complete the word.
- R2: Fetch visits micro-addresses 0, 1, 2 and 3 in order, one per clock, apart from the wait at address 1.
- R3: At a microinstruction that waits for memory (addresses 0x01, 0x4B, 0x4F, 0x78), the micro-PC holds while mfc is low. It advances on the first clock edge at which mfc is high.
- R4: Address 3 dispatches to disp_base OR (ir_mode << 2).
- R5: With ir_mode = 3'b001 (register) and base 0x41, execution runs 0x45, 0x46 and 0x47 and then returns to 0.
- R6: With ir_mode = 3'b011 (autoincrement, direct since bit 0 is set), execution runs 0x4D, 0x4E, 0x4F (waiting), 0x79, 0x7A and 0x7B. The jump from 0x4F targets 0x78 OR ir_mode[0], so the indirect read at 0x78 is skipped.
- R7: With ir_mode = 3'b010 (autoincrement, indirect), execution runs 0x49, 0x4A, 0x4B (waiting), 0x78 (waiting), 0x79, 0x7A and 0x7B.
- R8: At the conditional step 0x19, reached with base 0x19 and ir_mode 0, a clear n_flag sends the micro-PC to 0.
- R9: At 0x19 a set n_flag falls through to 0x1A and then 0x1B. At 0x1B the control word is 0x0082 (Z-out and PC-in).
- R10: end_op is high at 0x47, 0x7B and 0x1B, and the following micro-address is 0.
- R11: A control-store address with no routine, such as 0x5D reached through ir_mode = 3'b111, gives a zero control word with end_op high. The sequencer then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_mode | input | 3 | Addressing-mode field of the current instruction |
| disp_base | input | 8 | Routine start address from the instruction decoder |
| n_flag | input | 1 | Negative condition code |
| mfc | input | 1 | Memory operation complete |
| upc | output | 8 | Current micro-address |
| ctrl | output | 16 | Datapath control word |
| wait_mfc | output | 1 | Current microinstruction waits for memory |
| end_op | output | 1 | Last microinstruction of the instruction |

## Verification
The hardest case to reach is two waits in a row at 0x4B and 0x78 in the indirect route. There the completion pulse for the first wait must not carry over to the second. The bench answers every wait with a configurable latency, including zero, and predicts how many times each waiting address repeats. Both settings of the direct bit, and both settings of the negative flag, are run so that each side of every branch is traced address by address.

// File: rtl/useq.sv
module useq #(
  parameter int UA_W = 8,
  parameter int CW_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      ir_mode,
  input  logic [UA_W-1:0] disp_base,
  input  logic            n_flag,
  input  logic            mfc,
  output logic [UA_W-1:0] upc,
  output logic [CW_W-1:0] ctrl,
  output logic            wait_mfc,
  output logic            end_op
);
  localparam int MI_W = UA_W + 6 + CW_W;
  localparam int P_W  = CW_W;
  localparam int P_E  = CW_W + 1;
  localparam int P_NS = CW_W + 2;
  localparam int P_OM = CW_W + 4;
  localparam int P_OD = CW_W + 5;
  localparam int P_NX = CW_W + 6;

  localparam logic [1:0] NS_INC = 2'd0, NS_DISP = 2'd1, NS_COND = 2'd2, NS_JUMP = 2'd3;

  localparam logic [CW_W-1:0] PCO  = CW_W'(1) << 0;
  localparam logic [CW_W-1:0] PCI  = CW_W'(1) << 1;
  localparam logic [CW_W-1:0] MARI = CW_W'(1) << 2;
  localparam logic [CW_W-1:0] RD   = CW_W'(1) << 3;
  localparam logic [CW_W-1:0] SEL4 = CW_W'(1) << 4;
  localparam logic [CW_W-1:0] ADD  = CW_W'(1) << 5;
  localparam logic [CW_W-1:0] ZI   = CW_W'(1) << 6;
  localparam logic [CW_W-1:0] ZO   = CW_W'(1) << 7;
  localparam logic [CW_W-1:0] YI   = CW_W'(1) << 8;
  localparam logic [CW_W-1:0] MDRO = CW_W'(1) << 9;
  localparam logic [CW_W-1:0] IRI  = CW_W'(1) << 10;
  localparam logic [CW_W-1:0] RSO  = CW_W'(1) << 11;
  localparam logic [CW_W-1:0] RSI  = CW_W'(1) << 12;
  localparam logic [CW_W-1:0] RDO  = CW_W'(1) << 13;
  localparam logic [CW_W-1:0] RDI  = CW_W'(1) << 14;
  localparam logic [CW_W-1:0] OFFO = CW_W'(1) << 15;

  localparam logic [UA_W-1:0] A_IND = UA_W'('h78);

  function automatic logic [MI_W-1:0] mi(
    input logic [UA_W-1:0] nxt, input logic odir, input logic omode,
    input logic [1:0] ns, input logic e, input logic w, input logic [CW_W-1:0] c);
    return {nxt, odir, omode, ns, e, w, c};
  endfunction

  function automatic logic [MI_W-1:0] rom(input logic [UA_W-1:0] a);
    case (a)
      UA_W'('h00): rom = mi('0, 1'b0, 1'b0, NS_INC,  1'b0, 1'b0, PCO | MARI | RD | SEL4 | ADD | ZI);
      UA_W'('h01): rom = mi('0, 1'b0, 1'b0, NS_INC,  1'b0, 1'b1, ZO | PCI | YI);
      UA_W'('h02): rom = mi('0, 1'b0, 1'b0, NS_INC,  1'b0, 1'b0, MDRO | IRI);
      UA_W'('h03): rom = mi('0, 1'b0, 1'b1, NS_DISP, 1'b0, 1'b0, '0);
      UA_W'('h19): rom = mi('0, 1'b0, 1'b0, NS_COND, 1'b0, 1'b0, '0);
      UA_W'('h1A): rom = mi('0, 1'b0, 1'b0, NS_INC,  1'b0, 1'b0, OFFO | ADD | ZI);
      UA_W'('h1B): rom = mi('0, 1'b0, 1'b0, NS_INC,  1'b1, 1'b0, ZO | PCI);
      UA_W'('h45): rom = mi('0, 1'b0, 1'b0, NS_INC,  1'b0, 1'b0, RSO | YI);
      UA_W'('h46): rom = mi('0, 1'b0, 1'b0, NS_INC,  1'b0, 1'b0, RDO | ADD | ZI);
      UA_W'('h47): rom = mi('0, 1'b0, 1'b0, NS_INC,  1'b1, 1'b0, ZO | RDI);
      UA_W'('h49),
      UA_W'('h4D): rom = mi('0, 1'b0, 1'b0, NS_INC,  1'b0, 1'b0, RSO | MARI | RD | SEL4 | ADD | ZI);
      UA_W'('h4A),
      UA_W'('h4E): rom = mi('0, 1'b0, 1'b0, NS_INC,  1'b0, 1'b0, ZO | RSI);
      UA_W'('h4B),
      UA_W'('h4F): rom = mi(A_IND, 1'b1, 1'b0, NS_JUMP, 1'b0, 1'b1, '0);
      UA_W'('h78): rom = mi('0, 1'b0, 1'b0, NS_INC,  1'b0, 1'b1, MDRO | MARI | RD);
      UA_W'('h79): rom = mi('0, 1'b0, 1'b0, NS_INC,  1'b0, 1'b0, MDRO | YI);
      UA_W'('h7A): rom = mi('0, 1'b0, 1'b0, NS_INC,  1'b0, 1'b0, RDO | ADD | ZI);
      UA_W'('h7B): rom = mi('0, 1'b0, 1'b0, NS_INC,  1'b1, 1'b0, ZO | RDI);
      default:     rom = mi('0, 1'b0, 1'b0, NS_INC,  1'b1, 1'b0, '0);
    endcase
  endfunction

  logic [MI_W-1:0] word;
  logic [UA_W-1:0] fld, or_vec, base, nxt;
  logic [1:0]      nsel;
  logic            stall;

  assign word     = rom(upc);
  assign ctrl     = word[CW_W-1:0];
  assign wait_mfc = word[P_W];
  assign end_op   = word[P_E];
  assign nsel     = word[P_NS+1:P_NS];
  assign fld      = word[MI_W-1:P_NX];
  assign stall    = wait_mfc & ~mfc;
  assign base     = (nsel == NS_DISP) ? disp_base : fld;

  always_comb begin
    or_vec = '0;
    if (word[P_OM]) or_vec[4:2] = ir_mode;
    if (word[P_OD]) or_vec[0]   = ir_mode[0];
  end

  always_comb begin
    case (nsel)
      NS_INC:  nxt = upc + 1'b1;
      NS_COND: nxt = n_flag ? upc + 1'b1 : fld;
      default: nxt = base | or_vec;
    endcase
    if (stall)       nxt = upc;
    else if (end_op) nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) upc <= '0;
    else        upc <= nxt;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> upc == $past(upc)); // R3
  AST_END_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (end_op && !stall) |=> upc == '0); // R10
  AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (nsel == NS_INC && !stall && !end_op) |=> upc == $past(upc) + 1'b1); // R2
  AST_COND_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (nsel == NS_COND && !n_flag && !stall && !end_op) |=> upc == '0); // R8
  AST_DIRECT_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (nsel == NS_JUMP && ir_mode[0] && !stall && !end_op) |=> upc[0]); // R6
endmodule

// File: tb/useq_tb.sv
module useq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ir_mode = '0;
  logic [7:0]  disp_base = '0;
  logic        n_flag = 1'b0;
  logic        mfc = 1'b0;
  logic [7:0]  upc;
  logic [15:0] ctrl;
  logic        wait_mfc, end_op;

  int checks = 0, fails = 0, lat = 0, wcnt = 0;

  typedef struct {
    logic [7:0]  a;
    logic        endx;
    logic        cwchk;
    logic [15:0] cw;
    string       tag;
  } exp_t;
  exp_t q[$];
  exp_t cur;

  always #4 clk = ~clk;

  useq u_dut (.clk(clk), .rst_n(rst_n), .ir_mode(ir_mode), .disp_base(disp_base),
              .n_flag(n_flag), .mfc(mfc), .upc(upc), .ctrl(ctrl),
              .wait_mfc(wait_mfc), .end_op(end_op));

  always @(negedge clk) begin
    if (!rst_n) begin
      wcnt = 0; mfc = 1'b0;
    end else if (wait_mfc && wcnt < lat) begin
      wcnt = wcnt + 1; mfc = 1'b0;
    end else if (wait_mfc) begin
      wcnt = 0; mfc = 1'b1;
    end else begin
      wcnt = 0; mfc = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      cur = q.pop_front();
      checks++;
      if (upc !== cur.a || end_op !== cur.endx || (cur.cwchk && ctrl !== cur.cw)) begin
        fails++;
        $display("FAIL %s: upc=%h end=%b ctrl=%h expected upc=%h end=%b ctrl=%h",
                 cur.tag, upc, end_op, ctrl, cur.a, cur.endx, cur.cw);
      end
    end
  end

  task automatic push(input logic [7:0] a, input string tag,
                      input logic e = 1'b0, input logic ck = 1'b0, input logic [15:0] cw = '0);
    exp_t x;
    x.a = a; x.endx = e; x.cwchk = ck; x.cw = cw; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic push_w(input logic [7:0] a, input string tag);
    for (int i = 0; i <= lat; i++) push(a, tag);
  endtask

  task automatic push_fetch();
    push_w(8'h01, "R3 fetch wait");
    push(8'h02, "R2 fetch");
    push(8'h03, "R2 fetch");
  endtask

  task automatic setup(input logic [2:0] m, input logic [7:0] b, input logic n, input int l);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    ir_mode = m; disp_base = b; n_flag = n; lat = l;
  endtask

  task automatic go();
    #1 rst_n = 1'b1;
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    // R1 reset state
    setup(3'b001, 8'h41, 1'b0, 2);
    checks++;
    if (upc !== 8'h00 || ctrl !== 16'h007D || end_op !== 1'b0) begin
      fails++;
      $display("FAIL R1: upc=%h ctrl=%h end=%b expected upc=00 ctrl=007D end=0", upc, ctrl, end_op);
    end

    // R5 register mode, R4 dispatch, R10 end
    push_fetch();
    push(8'h45, "R4 dispatch reg");
    push(8'h46, "R5");
    push(8'h47, "R10 end reg", 1'b1);
    push(8'h00, "R10 return");
    go();

    // R6 autoincrement direct skips 0x78
    setup(3'b011, 8'h41, 1'b0, 1);
    push_fetch();
    push(8'h4D, "R4 dispatch autoinc");
    push(8'h4E, "R6");
    push_w(8'h4F, "R3 wait at 4F");
    push(8'h79, "R6 skip indirect");
    push(8'h7A, "R6");
    push(8'h7B, "R10 end autoinc", 1'b1);
    push(8'h00, "R10 return");
    go();

    // R7 autoincrement indirect, zero latency and long latency
    for (int k = 0; k < 2; k++) begin
      setup(3'b010, 8'h41, 1'b0, k * 3);
      push_fetch();
      push(8'h49, "R4 dispatch indirect");
      push(8'h4A, "R7");
      push_w(8'h4B, "R3 wait at 4B");
      push_w(8'h78, "R7 indirect read");
      push(8'h79, "R7");
      push(8'h7A, "R7");
      push(8'h7B, "R7 end", 1'b1);
      push(8'h00, "R10 return");
      go();
    end

    // R8 branch with N clear
    setup(3'b000, 8'h19, 1'b0, 1);
    push_fetch();
    push(8'h19, "R8 cond step");
    push(8'h00, "R8 back to fetch");
    go();

    // R9 branch with N set
    setup(3'b000, 8'h19, 1'b1, 1);
    push_fetch();
    push(8'h19, "R9 cond step");
    push(8'h1A, "R9 fall through");
    push(8'h1B, "R9 pc update", 1'b1, 1'b1, 16'h0082);
    push(8'h00, "R10 return");
    go();

    // R11 empty control-store slot
    setup(3'b111, 8'h41, 1'b0, 0);
    push_fetch();
    push(8'h5D, "R11 empty slot", 1'b1, 1'b1, 16'h0000);
    push(8'h00, "R11 return");
    go();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule